// File: doc/BRIEF.md
# Two-Stage Register-Mapped Watchdog Timer

This block is a watchdog peripheral on a simple synchronous 32-bit register bus. Once software enables it, a down-counter runs from a power-of-two timeout period. Software must keep restarting it by writing a fixed key value to a restart register. If the count runs out, the block responds in one of two ways, depending on a mode bit. In direct mode it asks for a system reset at once. In two-stage mode it first raises an interrupt and starts a second period. It asks for a reset only if that second period also runs out while the interrupt is still pending.

Two period selections are held in one register. The initial selection sets the first count after enabling. The running selection sets every reload after that. The enable cannot be withdrawn by software. The reset request is a fixed-length pulse. After the pulse, the block returns to its power-up state.

Register map, by byte offset: control at 0x00, period selection at 0x04, live count at 0x08, restart at 0x0C, interrupt status at 0x10, interrupt acknowledge at 0x14. Any other address reads as zero.

Top module: `twostage_wdt`

## Requirements
- R1: After `rst`, `irq_o` and `sys_rst_o` are low, and the control, period-selection, count and status registers all read 0.
- R2: Control bit 0 is the enable and bit 1 is the mode (0 = direct reset, 1 = interrupt first). Writing a 0 to bit 0 never clears an enable that is already set, and the count keeps running.
- R3: The write that sets the enable loads the counter with 2^(BASE_EXP+i) − 1, where i is period-selection bits [7:4].
- R4: Every later reload (a restart, or an expiry that does not end in reset) uses the index in bits [3:0]. A change to the period selection during a count takes effect only at the next reload.
- R5: Offset 0x08 reads the live count. While enabled, the count falls by one each clock cycle, so one period is 2^(BASE_EXP+i) cycles from load to expiry.
- R6: A write of exactly 0x00000076 to offset 0x0C while enabled reloads the counter and clears a pending interrupt. Any other value has no effect. The key value has no effect while the block is disabled.
- R7: In direct mode, expiry raises `sys_rst_o` on the cycle after the count reaches zero, and `irq_o` does not rise.
- R8: In two-stage mode, the first expiry sets the interrupt and reloads the counter. The interrupt is visible on `irq_o` and in bit 0 of offset 0x10.
- R9: In two-stage mode, an expiry while the interrupt is pending raises `sys_rst_o`.
- R10: A read strobe at offset 0x14 returns the interrupt status and clears it without reloading the counter. The next expiry then raises the interrupt again instead of a reset.
- R11: `sys_rst_o` stays high for exactly PULSE_LEN (8) cycles. When it falls, every register is back in its R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; it matters only at the acknowledge offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Pre-timeout interrupt, level |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
A wrong internal state shows up at the ports in a few ways:
- A bad load value or a bad decrement shows in the very next read of the live count, one cycle after the load.
- A wrong period selection moves the expiry edge. Sampling the outputs one cycle before and one cycle after the computed edge exposes it.
- A stale or wrongly cleared interrupt shows a full period later. The second expiry then gives the wrong response: a reset where an interrupt was due, or the reverse.
- A wrong pulse length or an incomplete clear-down shows when `sys_rst_o` falls and the control register is read back.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [31:0] KICK_KEY  = 32'h0000_0076;
    localparam logic [7:0]  OFS_CTRL  = 8'h00;
    localparam logic [7:0]  OFS_RANGE = 8'h04;
    localparam logic [7:0]  OFS_COUNT = 8'h08;
    localparam logic [7:0]  OFS_KICK  = 8'h0C;
    localparam logic [7:0]  OFS_STAT  = 8'h10;
    localparam logic [7:0]  OFS_ACK   = 8'h14;

    typedef enum logic {
        RESP_RESET     = 1'b0,
        RESP_IRQ_FIRST = 1'b1
    } resp_e;

    typedef struct packed {
        resp_e mode;
        logic  en;
    } ctrl_t;

    typedef struct packed {
        logic [3:0] init_idx;
        logic [3:0] run_idx;
    } range_t;

    // Last count value of a period: 2^(base+idx) - 1
    function automatic logic [63:0] period_last(input logic [3:0] idx, input int base);
        return (64'd1 << (base + int'(idx))) - 64'd1;
    endfunction

endpackage

// File: rtl/wdt_csr.sv
module wdt_csr
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [31:0]      addr,
    input  logic             we,
    input  logic             re,
    input  logic [31:0]      wdata,
    input  logic [CNT_W-1:0] count,
    input  logic             irq,
    output ctrl_t            ctrl,
    output range_t           range,
    output logic             arm,
    output logic             kick,
    output logic             ack,
    output logic [31:0]      rdata
);

    logic hit_ctrl, hit_range, hit_count, hit_kick, hit_stat, hit_ack;

    assign hit_ctrl  = (addr == {24'd0, OFS_CTRL});
    assign hit_range = (addr == {24'd0, OFS_RANGE});
    assign hit_count = (addr == {24'd0, OFS_COUNT});
    assign hit_kick  = (addr == {24'd0, OFS_KICK});
    assign hit_stat  = (addr == {24'd0, OFS_STAT});
    assign hit_ack   = (addr == {24'd0, OFS_ACK});

    assign arm  = we && hit_ctrl && wdata[0] && !ctrl.en;
    assign kick = we && hit_kick && (wdata == KICK_KEY) && ctrl.en;
    assign ack  = re && hit_ack;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ctrl  <= '0;
            range <= '0;
        end else begin
            if (we && hit_ctrl) begin
                ctrl.en   <= ctrl.en | wdata[0];
                ctrl.mode <= resp_e'(wdata[1]);
            end
            if (we && hit_range) begin
                range <= range_t'(wdata[7:0]);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_ctrl)  rdata = {30'd0, ctrl};
        if (hit_range) rdata = {24'd0, range};
        if (hit_count) rdata = 32'(count);
        if (hit_stat || hit_ack) rdata = {31'd0, irq};
    end

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             zero
);

    assign zero = (count == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (run && !zero) begin
            count <= count - CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdt_resp.sv
module wdt_resp
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  expire,
    input  resp_e mode,
    input  logic  kick,
    input  logic  ack,
    output logic  irq,
    output logic  pulse,
    output logic  reload,
    output logic  clr
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] pcnt;
    logic          fire;

    // A restart in the expiry cycle wins over the expiry
    assign fire   = expire && !kick && (mode == RESP_RESET || irq);
    assign reload = kick || (expire && !fire);
    assign clr    = pulse && (pcnt == PW'(PULSE_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            irq <= 1'b0;
        end else if (kick) begin
            irq <= 1'b0;
        end else if (expire && !fire && mode == RESP_IRQ_FIRST) begin
            irq <= 1'b1;
        end else if (ack) begin
            irq <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
            pcnt  <= '0;
        end else if (pulse) begin
            if (clr) begin
                pulse <= 1'b0;
                pcnt  <= '0;
            end else begin
                pcnt <= pcnt + PW'(1);
            end
        end else if (fire) begin
            pulse <= 1'b1;
            pcnt  <= '0;
        end
    end

endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
    import wdt_pkg::*;
#(
    parameter int BASE_EXP  = 16,
    parameter int PULSE_LEN = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] bus_addr,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        sys_rst_o
);

    localparam int CNT_W = BASE_EXP + 16;

    ctrl_t            ctrl;
    range_t           range;
    logic             arm, kick, ack, clr, reload, zero, expire;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] load_val;

    assign expire   = ctrl.en && zero && !sys_rst_o;
    assign load_val = arm ? CNT_W'(period_last(range.init_idx, BASE_EXP))
                          : CNT_W'(period_last(range.run_idx, BASE_EXP));

    wdt_csr #(.CNT_W(CNT_W)) u_csr (
        .clk(clk), .rst(rst), .clr(clr),
        .addr(bus_addr), .we(bus_we), .re(bus_re), .wdata(bus_wdata),
        .count(count), .irq(irq_o),
        .ctrl(ctrl), .range(range),
        .arm(arm), .kick(kick), .ack(ack), .rdata(bus_rdata)
    );

    wdt_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .clr(clr),
        .run(ctrl.en && !sys_rst_o), .load(arm || reload),
        .load_val(load_val), .count(count), .zero(zero)
    );

    wdt_resp #(.PULSE_LEN(PULSE_LEN)) u_resp (
        .clk(clk), .rst(rst), .expire(expire), .mode(ctrl.mode),
        .kick(kick), .ack(ack), .irq(irq_o), .pulse(sys_rst_o),
        .reload(reload), .clr(clr)
    );

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
    import wdt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PULSE_LEN = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [31:0]      bus_addr,
    input logic             bus_we,
    input logic [31:0]      bus_wdata,
    input ctrl_t            ctrl,
    input logic [CNT_W-1:0] count,
    input logic             irq_o,
    input logic             sys_rst_o
);

    logic [7:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) hi_cnt <= '0;
        else if (sys_rst_o) hi_cnt <= hi_cnt + 8'd1;
        else hi_cnt <= '0;
    end

    assert_pulse_len_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_o) |-> (hi_cnt == 8'(PULSE_LEN)));

    assert_en_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl.en) |-> $fell(sys_rst_o));

    assert_kick_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == {24'd0, OFS_KICK} && bus_wdata == KICK_KEY && ctrl.en)
        |=> !irq_o);

    assert_irq_on_expiry_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(count == '0 && ctrl.en && ctrl.mode == RESP_IRQ_FIRST));

    assert_rst_on_expiry_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_o) |-> $past(count == '0 && ctrl.en && (ctrl.mode == RESP_RESET || irq_o)));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && !sys_rst_o && count != '0 && !bus_we)
        |=> (count == $past(count) - CNT_W'(1)));

endmodule

bind twostage_wdt wdt_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .ctrl(ctrl), .count(count),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
);

// File: tb/twostage_wdt_tb.sv
module twostage_wdt_tb;

    localparam int BASE  = 2;
    localparam int PULSE = 8;
    localparam logic [31:0] A_CTRL = 32'h00, A_RANGE = 32'h04, A_COUNT = 32'h08,
                            A_KICK = 32'h0C, A_STAT = 32'h10, A_ACK = 32'h14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, sys_rst_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    twostage_wdt #(.BASE_EXP(BASE), .PULSE_LEN(PULSE)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
    endtask

    function automatic int per(input int i);
        return 1 << (BASE + i);
    endfunction

    initial begin
        logic [31:0] v;
        int p;
        int hi;
        @(negedge clk);
        do_reset();

        // R1: reset state
        rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
        rd(A_RANGE, v); chk("R1 range", v, 0);
        rd(A_COUNT, v); chk("R1 count", v, 0);
        rd(A_STAT, v);  chk("R1 status", v, 0);
        chk("R1 irq_o", {31'd0, irq_o}, 0);
        chk("R1 sys_rst_o", {31'd0, sys_rst_o}, 0);

        // R3 R5 R7 R11: direct-mode sweep over period indices
        for (int i = 0; i < 5; i++) begin
            p = per(i);
            do_reset();
            wr(A_RANGE, {24'd0, 4'(i), 4'(i)});
            wr(A_CTRL, 32'h1);
            rd(A_COUNT, v); chk("R3 initial load", v, p - 1);
            tick(1);
            rd(A_COUNT, v); chk("R5 decrement", v, p - 2);
            tick(p - 2);
            chk("R7 no reset before expiry", {31'd0, sys_rst_o}, 0);
            tick(1);
            chk("R7 reset on expiry", {31'd0, sys_rst_o}, 1);
            chk("R7 no irq in direct mode", {31'd0, irq_o}, 0);
            hi = 1;
            for (int k = 0; k < PULSE + 2; k++) begin
                tick(1);
                hi += int'(sys_rst_o);
            end
            chk("R11 pulse length", hi, PULSE);
            rd(A_CTRL, v); chk("R11 ctrl cleared", v, 0);
            rd(A_RANGE, v); chk("R11 range cleared", v, 0);
        end

        // R2: enable cannot be cleared
        do_reset();
        wr(A_RANGE, 32'h55);
        wr(A_CTRL, 32'h1);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v);  chk("R2 enable sticky", v, 1);
        rd(A_COUNT, v); chk("R2 count still running", v, per(5) - 2);

        // R4 R6: initial vs running index, key filtering
        do_reset();
        wr(A_RANGE, 32'h13);
        wr(A_CTRL, 32'h1);
        tick(2);
        rd(A_COUNT, v); chk("R3 init index used", v, per(1) - 3);
        wr(A_KICK, 32'h77);
        rd(A_COUNT, v); chk("R6 wrong key ignored", v, per(1) - 4);
        wr(A_KICK, 32'h176);
        rd(A_COUNT, v); chk("R6 wide key ignored", v, per(1) - 5);
        wr(A_KICK, 32'h76);
        rd(A_COUNT, v); chk("R4 restart uses run index", v, per(3) - 1);
        wr(A_RANGE, 32'h12);
        rd(A_COUNT, v); chk("R4 no mid-count change", v, per(3) - 2);
        wr(A_KICK, 32'h76);
        rd(A_COUNT, v); chk("R4 new index at reload", v, per(2) - 1);

        // R6: key while disabled
        do_reset();
        wr(A_RANGE, 32'h02);
        wr(A_KICK, 32'h76);
        rd(A_COUNT, v); chk("R6 disabled key no load", v, 0);
        tick(10);
        chk("R6 disabled no irq", {31'd0, irq_o}, 0);
        chk("R6 disabled no reset", {31'd0, sys_rst_o}, 0);

        // R8 R9 R11: two-stage mode
        p = per(2);
        do_reset();
        wr(A_RANGE, 32'h22);
        wr(A_CTRL, 32'h3);
        tick(p - 1);
        chk("R8 irq low before expiry", {31'd0, irq_o}, 0);
        tick(1);
        chk("R8 irq on first expiry", {31'd0, irq_o}, 1);
        rd(A_STAT, v);  chk("R8 status bit", v, 1);
        rd(A_COUNT, v); chk("R8 reload after first expiry", v, p - 1);
        chk("R8 no reset on first expiry", {31'd0, sys_rst_o}, 0);
        tick(p - 1);
        chk("R9 no reset before second expiry", {31'd0, sys_rst_o}, 0);
        tick(1);
        chk("R9 reset on second expiry", {31'd0, sys_rst_o}, 1);
        tick(PULSE);
        chk("R11 pulse over", {31'd0, sys_rst_o}, 0);
        chk("R11 irq cleared", {31'd0, irq_o}, 0);

        // R6: restart clears pending interrupt
        do_reset();
        wr(A_RANGE, 32'h22);
        wr(A_CTRL, 32'h3);
        tick(p);
        chk("R8 irq set", {31'd0, irq_o}, 1);
        wr(A_KICK, 32'h76);
        chk("R6 restart clears irq", {31'd0, irq_o}, 0);
        rd(A_COUNT, v); chk("R6 restart reloads", v, p - 1);

        // R10: acknowledge read
        do_reset();
        wr(A_RANGE, 32'h22);
        wr(A_CTRL, 32'h3);
        tick(p);
        bus_addr = A_ACK; bus_re = 1'b1;
        #1 chk("R10 ack read returns status", bus_rdata, 1);
        @(negedge clk);
        bus_re = 1'b0;
        chk("R10 ack clears irq", {31'd0, irq_o}, 0);
        rd(A_COUNT, v); chk("R10 ack does not reload", v, p - 2);
        tick(p - 2);
        chk("R10 irq low before next expiry", {31'd0, irq_o}, 0);
        tick(1);
        chk("R10 irq again, not reset", {31'd0, irq_o}, 1);
        chk("R10 no reset after ack", {31'd0, sys_rst_o}, 0);
        tick(p);
        chk("R9 reset after unserviced irq", {31'd0, sys_rst_o}, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule